// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns a parallel word into one asynchronous serial frame on a line that rests high. Each frame has a low start bit, then eight or nine data slots sent least significant bit first, then a high stop bit. An external divider supplies a one-cycle `baud_tick` enable, and every bit boundary falls on one of those ticks. A one-cycle `load` strobe, given while the block is idle, captures the word and the frame options.

When parity is enabled the frame does not grow. The highest data slot carries a generated parity bit in place of the word's top bit. In eight-slot mode that is slot 7, and parity covers word bits 6..0. In nine-slot mode it is slot 8, and parity covers word bits 7..0.

The controller has four states. IDLE moves to START on `load`. START moves to DATA on a tick. DATA stays in DATA on a tick until the last slot has been sent, then moves to STOP on that slot's tick. STOP moves to IDLE on a tick and raises `done`. Without a tick every state except IDLE holds. IDLE holds without `load`.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `done` is 0.
- R2: A `load` in IDLE makes `busy` 1 and `txd` 0 (start bit) in the next cycle. The start bit lasts until the first `baud_tick` after the load.
- R3: After the start bit, the data slots go out least significant bit first. Each slot changes only on a `baud_tick`. There are 8 slots when `wide9`=0 and 9 slots when `wide9`=1.
- R4: After the last data slot, `txd` is 1 (stop bit) for one tick interval. The block then returns to IDLE with `txd` 1.
- R5: With `par_en`=1, the top slot (slot 7 if `wide9`=0, slot 8 if `wide9`=1) carries the parity bit instead of word bit 7 or 8. The lower slots carry the word bits unchanged.
- R6: With `par_odd`=0, the parity bit makes the number of ones in the covered low bits plus the parity bit even. With `par_odd`=1 it makes that number odd. Example: word 00110101 gives parity 0 for even and 1 for odd.
- R7: With `par_en`=0, every slot carries its word bit, including bit 8 in nine-slot mode. In eight-slot mode `tx_word[8]` is not sent.
- R8: A `load` while `busy` is 1 is ignored. Word, length and parity inputs are captured only at an accepted load, so changing them during a frame has no effect on it.
- R9: `done` is high for exactly one cycle: the cycle after the stop bit's closing tick, which is also the first cycle with `busy` 0.
- R10: A `load` in the cycle where `done` is high is accepted, so frames can run back to back.
- R11: A `baud_tick` while idle has no effect: `txd` stays 1 and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | 9 | Word to send |
| load | input | 1 | One-cycle request to start a frame |
| wide9 | input | 1 | 1 = nine data slots, 0 = eight |
| par_en | input | 1 | 1 = top slot carries parity |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| baud_tick | input | 1 | Bit-rate enable, one cycle wide |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at end of frame |

## Verification
Two events can coincide: the end-of-frame `done` pulse and a new `load`. The bench raises `load` with a new word in exactly the cycle where `done` is high. It then expects a start bit in the next cycle and a full, correct second frame, with no idle gap and no lost strobe. A `load` inside a running frame, given together with changed length and parity inputs, is judged by checking that the current frame finishes unchanged and that no second frame follows.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_t;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] word,
    input  logic              wide,
    input  logic              odd,
    output logic              par
);

    // Covered bits: DATA_W-1 low bits when wide, DATA_W-2 otherwise.
    always_comb begin
        par = odd;
        for (int i = 0; i < DATA_W - 1; i++) begin
            if ((i < DATA_W - 2) || wide) begin
                par = par ^ word[i];
            end
        end
    end

endmodule

// File: rtl/uart_tx_payload.sv
module uart_tx_payload #(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] word,
    input  logic              wide,
    input  logic              par_en,
    input  logic              par,
    output logic [DATA_W-1:0] payload
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_slot
        if (i == DATA_W - 1) begin : g_top_wide
            assign payload[i] = !wide ? 1'b0 : (par_en ? par : word[i]);
        end else if (i == DATA_W - 2) begin : g_top_narrow
            assign payload[i] = (par_en && !wide) ? par : word[i];
        end else begin : g_plain
            assign payload[i] = word[i];
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              load,
    input  logic              wide9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              baud_tick,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    import uart_tx_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(DATA_W - 2);

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_q;
    logic              done_q;
    logic              par_bit;
    logic [DATA_W-1:0] payload;

    uart_tx_parity #(.DATA_W(DATA_W)) u_parity (
        .word (tx_word),
        .wide (wide9),
        .odd  (par_odd),
        .par  (par_bit)
    );

    uart_tx_payload #(.DATA_W(DATA_W)) u_payload (
        .word    (tx_word),
        .wide    (wide9),
        .par_en  (par_en),
        .par     (par_bit),
        .payload (payload)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load)      state_d = ST_START;
            ST_START: if (baud_tick) state_d = ST_DATA;
            ST_DATA:  if (baud_tick && (cnt_q == last_q)) state_d = ST_STOP;
            ST_STOP:  if (baud_tick) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: shifter, slot counter, done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_STOP) && baud_tick;
            if ((state_q == ST_IDLE) && load) begin
                shreg_q <= payload;
                cnt_q   <= '0;
                last_q  <= wide9 ? LAST_WIDE : LAST_NARROW;
            end else if ((state_q == ST_DATA) && baud_tick) begin
                shreg_q <= shreg_q >> 1;
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state_q)
            ST_IDLE:  begin txd = 1'b1; busy = 1'b0; end
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg_q[0];
            ST_STOP:  txd = 1'b1;
            default:  begin txd = 1'b1; busy = 1'b0; end
        endcase
        done = done_q;
    end

    // Assertions
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(baud_tick)) |-> $stable(txd));

    a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (cnt_q <= last_q));

    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] tx_word = '0;
    logic       load = 1'b0;
    logic       wide9 = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, busy, done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_frame_tx u_uart_frame_tx (
        .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .load(load),
        .wide9(wide9), .par_en(par_en), .par_odd(par_odd),
        .baud_tick(baud_tick), .txd(txd), .busy(busy), .done(done)
    );

    // {word[8:0], wide9, par_en, par_odd, expected parity}
    localparam logic [12:0] VEC [10] = '{
        {9'h035, 1'b0, 1'b1, 1'b0, 1'b0},
        {9'h035, 1'b0, 1'b1, 1'b1, 1'b1},
        {9'h0B5, 1'b0, 1'b1, 1'b0, 1'b0},
        {9'h135, 1'b1, 1'b1, 1'b0, 1'b0},
        {9'h1FF, 1'b1, 1'b1, 1'b1, 1'b1},
        {9'h0A7, 1'b1, 1'b1, 1'b0, 1'b1},
        {9'h1A5, 1'b1, 1'b0, 1'b0, 1'b0},
        {9'h1C3, 1'b0, 1'b0, 1'b0, 1'b0},
        {9'h07F, 1'b0, 1'b1, 1'b1, 1'b0},
        {9'h001, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge in idle; leaves at the negedge showing the start bit.
    task automatic start_frame(input logic [8:0] w, input logic wd, input logic pe, input logic od);
        tx_word = w; wide9 = wd; par_en = pe; par_odd = od; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R2 busy", busy, 1'b1);
        chk("R2 start bit", txd, 1'b0);
        @(negedge clk);
        chk("R2 start held", txd, 1'b0);
    endtask

    task automatic tick_once();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    // Sends data and stop slots; leaves at the negedge where done should be high.
    task automatic body_frame(input logic [8:0] exp_bits, input int nb, input string req);
        for (int i = 0; i < nb; i++) begin
            tick_once();
            chk(req, txd, exp_bits[i]);
            @(negedge clk);
            chk("R3 hold", txd, exp_bits[i]);
        end
        tick_once();
        chk("R4 stop bit", txd, 1'b1);
        chk("R4 busy in stop", busy, 1'b1);
        tick_once();
        chk("R9 done", done, 1'b1);
        chk("R9 busy low", busy, 1'b0);
        chk("R4 idle high", txd, 1'b1);
    endtask

    function automatic logic [8:0] expect_bits(input logic [12:0] v);
        logic [8:0] w = v[12:4];
        logic [8:0] e = w;
        int nb = v[3] ? 9 : 8;
        if (v[2]) e[nb-1] = v[0];
        if (!v[3]) e[8] = 1'b0;
        return e;
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 txd", txd, 1'b1);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 R5 R6 R7
        for (int k = 0; k < 10; k++) begin
            logic [12:0] v = VEC[k];
            start_frame(v[12:4], v[3], v[2], v[1]);
            body_frame(expect_bits(v), v[3] ? 9 : 8, v[2] ? "R5 R6 slot" : "R7 slot");
            @(negedge clk);
            chk("R9 done single", done, 1'b0);
        end

        // R11: ticks while idle
        for (int k = 0; k < 3; k++) begin
            tick_once();
            chk("R11 txd", txd, 1'b1);
            chk("R11 busy", busy, 1'b0);
        end

        // R8: load while busy, with changed options
        start_frame(9'h055, 1'b0, 1'b0, 1'b0);
        tx_word = 9'h1AA; wide9 = 1'b1; par_en = 1'b1; par_odd = 1'b1; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R8 start kept", txd, 1'b0);
        body_frame(9'h055, 8, "R8 slot");
        @(negedge clk);
        chk("R8 no second frame", busy, 1'b0);
        chk("R8 line idle", txd, 1'b1);

        // R10: load in the done cycle
        start_frame(9'h0F0, 1'b0, 1'b0, 1'b0);
        body_frame(9'h0F0, 8, "R10 first slot");
        tx_word = 9'h10F; wide9 = 1'b1; par_en = 1'b0; par_odd = 1'b0; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R10 busy", busy, 1'b1);
        chk("R10 start", txd, 1'b0);
        chk("R10 done gone", done, 1'b0);
        body_frame(9'h10F, 9, "R10 second slot");
        @(negedge clk);
        chk("R9 done single", done, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule